// File: doc/BRIEF.md
# Look-Ahead Pipelined First-Order Recursive Filter

This block implements the first-order recursion y(n+1) = a·y(n) + b·u(n) on a stream of signed Q1.15 samples, one sample per clock. A direct implementation would need a multiply and an add to finish inside one clock period, because each output feeds the next. This block instead rewrites the recursion M steps ahead. Each output is then built from the output M samples earlier, scaled by a^M, plus a weighted sum of the last M inputs with weights b·a^i. The feedback loop can therefore hold M registers: one after the multiplier, one after the adder, and M-2 plain delays. The loop multiply-add gets a whole clock cycle per stage.

The weighted input sum is produced by a transposed non-recursive section, so the recursive part never waits for it. All coefficients (a^M and the M tap weights) are computed at elaboration time from the two parameters `COEF_A` and `COEF_B`. They are rounded half-up to Q1.15. The loop registers reset to zero, which is the causal start with zero history, so the output matches the plain recursion from the first sample on. Results are rounded once per loop pass and saturated to 16 bits.

The recursion advances on every clock. A cycle with no valid input is treated as a zero sample. The valid flag travels alongside the data with a fixed latency of three cycles.

Top module: `la_iir_top`

## Requirements
- R1: While `rst` is high, and in the cycle after each reset edge, `out_valid` is 0 and `out_data` is 0. Reset clears all filter state, so the first output after reset depends only on samples entered after reset.
- R2: `out_valid` is 1 exactly three clock cycles after each cycle in which `in_valid` was 1, and 0 in every other cycle.
- R3: Samples are signed two's-complement Q1.15, with value = code/32768. When no overflow occurs, each valid output is within ±1 LSB of the plain recursion y_k = a·y_{k-1} + b·x_k. Here a = COEF_A/32768, b = COEF_B/32768, x_k is the k-th input slot, and y is 0 before the first sample after reset.
- R4: For a single sample u entered right after reset and followed by zeros, the outputs are exactly round(b·u·a^k) for k = 0 … M+1, when these values are representable in Q1.15.
- R5: A cycle with `in_valid` low enters the recursion as a zero sample, whatever `in_data` holds. The state advances one step, scaled by a, and no valid output is produced for that slot.
- R6: A result outside the Q1.15 range is clipped to 32767 or -32768 and never wraps. With an alternating full-scale input, the output settles on those two extremes.
- R7: A constant input u settles to b·u/(1-a) within ±1 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a sample in this cycle |
| in_data | input | DW | Input sample, signed Q1.15 |
| out_valid | output | 1 | Marks `out_data` as a filtered sample |
| out_data | output | DW | Output sample, signed Q1.15, rounded and saturated |

## Verification
The assertions take for granted that `rst` is held high from time zero for at least one rising edge. They also assume the weighted input sum and the loop product fit the accumulator, which holds when the sum of the tap-weight magnitudes plus |a^M| stays below the accumulator headroom. The stimulus uses the default coefficients (a = -0.75, b = 0.5), whose powers are exact in Q1.15. It keeps ordinary input amplitudes within ±0.4, so the plain recursion never overflows. Only the saturation scenario deliberately drives full-scale alternating samples, and it is followed by a fresh reset.

// File: rtl/la_iir_pkg.sv
package la_iir_pkg;

  // Wide signed container used for elaboration-time coefficient math
  // and for rounding the loop accumulator back to sample width.
  typedef logic signed [63:0] wide_t;

  // Round half-up by dropping `frac` fraction bits, then clamp to a
  // signed `w`-bit range.
  function automatic wide_t fx_round_sat(input wide_t v, input int frac, input int w);
    wide_t r;
    wide_t hi;
    wide_t lo;
    r  = (v + (wide_t'(1) <<< (frac - 1))) >>> frac;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (w - 1));
    if (r > hi) begin
      r = hi;
    end else if (r < lo) begin
      r = lo;
    end
    return r;
  endfunction

  // Fixed-point product of two values that share `frac` fraction bits.
  function automatic wide_t fx_mul(input wide_t x, input wide_t y, input int frac, input int w);
    return fx_round_sat(x * y, frac, w);
  endfunction

  // scale * base^n, rounded after each multiply.
  function automatic wide_t fx_pow_scale(input wide_t base, input wide_t scale,
                                         input int n, input int frac, input int w);
    wide_t acc;
    acc = scale;
    for (int k = 0; k < n; k++) begin
      acc = fx_mul(acc, base, frac, w);
    end
    return acc;
  endfunction

  // Accumulator width that holds `terms` full products of two w-bit values.
  function automatic int acc_width(input int w, input int terms);
    return 2 * w + $clog2(terms + 1) + 1;
  endfunction

endpackage

// File: rtl/la_sample_gate.sv
// Captures one input slot per clock; an empty slot becomes a zero sample.
module la_sample_gate #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 slot_valid,
  output logic signed [DW-1:0] slot_data
);

  logic signed [DW-1:0] gated;

  assign gated = in_valid ? in_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_data  <= '0;
    end else begin
      slot_valid <= in_valid;
      slot_data  <= gated;
    end
  end

endmodule

// File: rtl/la_input_fir.sv
// Transposed non-recursive section: part[0] holds
// sum_{j} (b*a^j) * x(n-j) one clock after x(n) arrives.
module la_input_fir #(
  parameter int          DW     = 16,
  parameter int          TAPS   = 5,
  parameter int          ACC_W  = 36,
  parameter logic signed [DW-1:0] COEF_A = -16'sd24576,
  parameter logic signed [DW-1:0] COEF_B = 16'sd16384
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DW-1:0]    x,
  output logic signed [ACC_W-1:0] feed
);
  import la_iir_pkg::*;

  localparam int FRAC = DW - 1;

  logic signed [ACC_W-1:0] prod_ext [TAPS];
  logic signed [ACC_W-1:0] part     [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    localparam wide_t WEIGHT = fx_pow_scale(wide_t'(COEF_A), wide_t'(COEF_B), j, FRAC, DW);
    localparam logic signed [DW-1:0] WEIGHT_Q = WEIGHT[DW-1:0];
    logic signed [2*DW-1:0] prod;
    assign prod        = WEIGHT_Q * x;
    assign prod_ext[j] = ACC_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS; j++) begin
        part[j] <= '0;
      end
    end else begin
      for (int j = 0; j < TAPS - 1; j++) begin
        part[j] <= part[j+1] + prod_ext[j];
      end
      part[TAPS-1] <= prod_ext[TAPS-1];
    end
  end

  assign feed = part[0];

endmodule

// File: rtl/la_feedback_loop.sv
// Recursive loop with LOOK_M registers:
//   y_q(t) = sat(round(a^M * y_q(t-M) + feed(t-1)))
// Registers: product stage, sum stage, then LOOK_M-2 plain delays.
module la_feedback_loop #(
  parameter int          DW     = 16,
  parameter int          LOOK_M = 5,
  parameter int          ACC_W  = 36,
  parameter logic signed [DW-1:0] COEF_A = -16'sd24576
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] feed,
  output logic signed [ACC_W-1:0] prod_q,
  output logic signed [DW-1:0]    y_q
);
  import la_iir_pkg::*;

  localparam int    FRAC  = DW - 1;
  localparam int    DLY   = LOOK_M - 2;
  localparam wide_t A_POW = fx_pow_scale(wide_t'(COEF_A), wide_t'(1) <<< FRAC, LOOK_M, FRAC, DW);
  localparam logic signed [DW-1:0] A_POW_Q = A_POW[DW-1:0];

  logic signed [DW-1:0]    y_tap;
  logic signed [2*DW-1:0]  prod_c;
  logic signed [ACC_W-1:0] sum_c;
  wide_t                   y_wide;
  logic signed [DW-1:0]    y_next;

  assign prod_c = A_POW_Q * y_tap;
  assign sum_c  = prod_q + feed;
  assign y_wide = fx_round_sat(wide_t'(sum_c), FRAC, DW);
  assign y_next = y_wide[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      y_q    <= '0;
    end else begin
      prod_q <= ACC_W'(prod_c);
      y_q    <= y_next;
    end
  end

  if (DLY > 0) begin : g_chain
    logic signed [DW-1:0] chain [DLY];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < DLY; k++) begin
          chain[k] <= '0;
        end
      end else begin
        chain[0] <= y_q;
        for (int k = 1; k < DLY; k++) begin
          chain[k] <= chain[k-1];
        end
      end
    end
    assign y_tap = chain[DLY-1];
  end else begin : g_direct
    assign y_tap = y_q;
  end

endmodule

// File: rtl/la_valid_delay.sv
// Fixed-depth delay line for the sample-valid flag.
module la_valid_delay #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  output logic v_out
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= v_in;
      for (int k = 1; k < STAGES; k++) begin
        pipe[k] <= pipe[k-1];
      end
    end
  end

  assign v_out = pipe[STAGES-1];

endmodule

// File: rtl/la_iir_top.sv
// Look-ahead pipelined first-order recursive filter.
// Latency: gate (1) + input section (1) + loop sum register (1) = 3.
module la_iir_top #(
  parameter int          DW     = 16,
  parameter int          LOOK_M = 5,
  parameter logic signed [DW-1:0] COEF_A = -16'sd24576,
  parameter logic signed [DW-1:0] COEF_B = 16'sd16384
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  import la_iir_pkg::*;

  localparam int ACC_W      = acc_width(DW, LOOK_M);
  localparam int POST_STAGES = 2;

  logic                    slot_valid;
  logic signed [DW-1:0]    slot_data;
  // Named internal events for the checker.
  logic signed [ACC_W-1:0] loop_feed;
  logic signed [ACC_W-1:0] loop_prod;

  la_sample_gate #(.DW(DW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .slot_valid (slot_valid),
    .slot_data  (slot_data)
  );

  la_input_fir #(
    .DW     (DW),
    .TAPS   (LOOK_M),
    .ACC_W  (ACC_W),
    .COEF_A (COEF_A),
    .COEF_B (COEF_B)
  ) u_fir (
    .clk  (clk),
    .rst  (rst),
    .x    (slot_data),
    .feed (loop_feed)
  );

  la_feedback_loop #(
    .DW     (DW),
    .LOOK_M (LOOK_M),
    .ACC_W  (ACC_W),
    .COEF_A (COEF_A)
  ) u_loop (
    .clk    (clk),
    .rst    (rst),
    .feed   (loop_feed),
    .prod_q (loop_prod),
    .y_q    (out_data)
  );

  la_valid_delay #(.STAGES(POST_STAGES)) u_vdly (
    .clk   (clk),
    .rst   (rst),
    .v_in  (slot_valid),
    .v_out (out_valid)
  );

endmodule

// File: rtl/la_iir_checker.sv
module la_iir_checker #(
  parameter int DW    = 16,
  parameter int ACC_W = 36
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [DW-1:0]    out_data,
  input logic signed [ACC_W-1:0] loop_prod,
  input logic signed [ACC_W-1:0] loop_feed
);

  // Edges since reset release, saturating at the pipeline latency.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  // R1: reset leaves the output idle and zero.
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2: valid output three cycles after each valid input.
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: two non-negative loop terms never give a negative sample.
  a_r6_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
    (loop_prod >= 0 && loop_feed >= 0) |=> (out_data >= 0));

  // R6: two negative loop terms never give a positive sample.
  a_r6_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (loop_prod < 0 && loop_feed < 0) |=> (out_data <= 0));

endmodule

bind la_iir_top la_iir_checker #(.DW(DW), .ACC_W(ACC_W)) u_la_iir_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .loop_prod (loop_prod),
  .loop_feed (loop_feed)
);

// File: tb/test_la_iir_top.sv
`timescale 1ns/1ps
module test_la_iir_top;

  localparam int DW = 16;
  localparam int LOOK_M = 5;
  localparam logic signed [DW-1:0] CA = -16'sd24576;  // a = -0.75
  localparam logic signed [DW-1:0] CB = 16'sd16384;   // b =  0.5
  localparam int HN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  always #10 clk = ~clk;

  la_iir_top #(.DW(DW), .LOOK_M(LOOK_M), .COEF_A(CA), .COEF_B(CB)) i_la_iir_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  real ra = real'(CA) / 32768.0;
  real rb = real'(CB) / 32768.0;
  real yref;
  int cyc;
  bit    hv[HN];
  bit    hchk[HN];
  int    he[HN];
  int    htol[HN];
  string htag[HN];

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int quant(input real y);
    real t;
    t = $floor(y * 32768.0 + 0.5);
    if (t > 32767.0) t = 32767.0;
    if (t < -32768.0) t = -32768.0;
    return int'(t);
  endfunction

  // One input slot: verify the slot entered three cycles earlier, then
  // drive this slot and advance the plain (non-look-ahead) model.
  task automatic tick(input bit v, input int d, input int tol, input bit dchk, input string tag);
    int s;
    int dlt;
    real x;
    @(negedge clk);
    if (cyc >= 3) begin
      s = (cyc - 3) % HN;
      check("R2 valid timing", out_valid == hv[s], int'(out_valid), int'(hv[s]));
      if (hv[s] && hchk[s]) begin
        dlt = int'(out_data) - he[s];
        check(htag[s], dlt <= htol[s] && dlt >= -htol[s], int'(out_data), he[s]);
      end
    end
    in_valid = v;
    in_data  = DW'(d);
    x = v ? real'(d) / 32768.0 : 0.0;
    yref = ra * yref + rb * x;
    if (yref > 32767.0 / 32768.0) yref = 32767.0 / 32768.0;
    if (yref < -1.0) yref = -1.0;
    s = cyc % HN;
    hv[s] = v; hchk[s] = dchk; he[s] = quant(yref); htol[s] = tol; htag[s] = tag;
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (2) @(negedge clk);
    check("R1 reset valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R1 reset data", out_data == '0, int'(out_data), 0);
    rst = 1'b0;
    yref = 0.0;
    cyc = 0;
  endtask

  task automatic drain();
    repeat (4) tick(1'b0, 0, 1, 1'b1, "R2 drain");
  endtask

  task automatic t_idle();
    do_reset();
    repeat (10) tick(1'b0, 12345, 1, 1'b1, "R2 idle");
    check("R1 idle data stays zero", out_data == '0, int'(out_data), 0);
  endtask

  task automatic t_impulse();
    do_reset();
    tick(1'b1, 16384, 0, 1'b1, "R4 impulse first (R1 clean start)");
    for (int k = 1; k <= LOOK_M + 1; k++) tick(1'b1, 0, 0, 1'b1, "R4 impulse exact");
    repeat (12) tick(1'b1, 0, 1, 1'b1, "R3 impulse tail");
    drain();
  endtask

  task automatic t_step();
    do_reset();
    repeat (43) tick(1'b1, 8192, 1, 1'b1, "R3 step");
    // closed form b*u/(1-a) = 0.5*0.25/1.75
    check("R7 dc level", int'(out_data) >= 2340 && int'(out_data) <= 2342, int'(out_data), 2341);
    drain();
  endtask

  task automatic t_gaps();
    logic [15:0] lf;
    int d;
    do_reset();
    tick(1'b1, 16384, 0, 1'b1, "R5 gap impulse");
    tick(1'b0, 32767, 0, 1'b1, "R5 gap garbage ignored");
    tick(1'b1, 0, 0, 1'b1, "R5 after gap a^2 step");
    lf = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = int'(lf % 16'd26000) - 13000;
      if (k % 3 == 2) tick(1'b0, -32768, 1, 1'b1, "R5 gap stream");
      else tick(1'b1, d, 1, 1'b1, "R3 random stream");
    end
    drain();
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 40; k++) begin
      tick(1'b1, (k % 2 == 0) ? 32767 : -32768, 0, k >= 10, "R6 saturation");
    end
    repeat (3) tick(1'b1, 32767, 0, 1'b0, "R6 settle");
    check("R6 output at extreme", out_data == 16'sh7FFF || out_data == -16'sh8000,
          int'(out_data), 32767);
    // reset straight after saturation: state must be gone
    do_reset();
    tick(1'b1, 16384, 0, 1'b1, "R1 post-reset clean impulse");
    repeat (3) tick(1'b1, 0, 0, 1'b1, "R1 post-reset tail");
    drain();
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    yref = 0.0;
    cyc = 0;
    t_idle();
    t_impulse();
    t_step();
    t_gaps();
    t_saturate();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule